// File: doc/BRIEF.md
# Interrupt Priority Resolver and Vector Selector

This block sits behind the capture and masking stage of an interrupt controller. Each cycle it receives one bit per interrupt that says whether the request is pending and enabled, and a second bit that assigns the request to one of two classes: normal (IRQ) or fast (FIQ). Two arbiters run in parallel, one per class. Each picks the most urgent request of its class from the programmed priorities. For each class the block then outputs a packed status word and the word-aligned handler address of the winner.

A small register bus holds the configuration: one 4-bit priority and one 30-bit vector address per interrupt, a fallback vector, and a read-only word that gives the interrupt count. A per-interrupt input flag reports an uncorrectable error on a stored vector. When that flag is set for the winning interrupt, the fallback vector is output in place of the stored one. The interrupt count is a parameter. The arbitration is combinational, and the class outputs are registered, so they appear one cycle later.

The bus layout is as follows:
- Byte offset 0x000 is the info word.
- Byte offset 0x004 is the fallback vector.
- Byte offset 0x400 + 4·i is the priority of interrupt i.
- Byte offset 0x800 + 4·i is the vector of interrupt i.

Writes take effect at the clock edge. Reads are combinational. Any other address reads 0.

Top module: `irq_prio_resolver`

## Requirements
- R1: Every priority register resets to 0xF. Bits 3:0 are writable. Bits 31:4 always read 0, and writes to them are ignored.
- R2: Within a class, the candidate with the numerically lowest priority value wins.
- R3: If candidates have equal priority, the one with the lowest interrupt number wins.
- R4: Each status output is packed as follows: bit 31 = valid, bits 19:16 = winning priority, bits 9:0 = winning interrupt number. All other bits are 0.
- R5: The two classes are resolved independently. A request with `req_fiq`=1 competes only in the FIQ class, and a request with `req_fiq`=0 competes only in the IRQ class.
- R6: Bits 31:2 of every vector register are writable. Bits 1:0 always read 0.
- R7: Each class vector output equals the stored vector of that class's winner.
- R8: The fallback vector register stores bits 31:2, and bits 1:0 read 0. When `vec_ded` is set for the winning interrupt, the fallback vector replaces the stored vector on that class's vector output.
- R9: The info word reads the interrupt count in bits 10:0 and 0 in all other bits. Writes to it are ignored.
- R10: When a class has no candidate, its status output and its vector output are both 0. This includes the state after reset.
- R11: The outputs reflect the inputs and configuration sampled at the previous clock edge. A priority write therefore shows at the outputs two edges after it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pend | input | N_INT | Pending and enabled request, one bit per interrupt |
| req_fiq | input | N_INT | Class of each interrupt: 1 = FIQ, 0 = IRQ |
| vec_ded | input | N_INT | Uncorrectable error flag on each stored vector |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_stat | output | 32 | IRQ winner status word |
| fiq_stat | output | 32 | FIQ winner status word |
| irq_vec | output | 32 | IRQ winner vector address |
| fiq_vec | output | 32 | FIQ winner vector address |

## Verification
A corrupted priority or vector entry stays hidden until its interrupt wins a class. At that point it shows up one cycle later as a wrong number or priority in the status word, or as a wrong address. The table of request patterns therefore arranges for many different entries to win, in both classes and together with the fallback flag. A broken comparison or tie-break shows on the first pattern with contested priorities. Register readback exposes stored state at once, with no arbitration needed, so the bench reads reset values and masked bits directly.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int PRI_W = 4;
    localparam int VEC_W = 30;
    localparam int NUM_W = 10;
    localparam int ADR_W = 12;

    // address region, bits 11:10 of the byte address
    localparam logic [1:0] RGN_CTRL = 2'b00;
    localparam logic [1:0] RGN_PRI  = 2'b01;
    localparam logic [1:0] RGN_VEC  = 2'b10;

    // slots inside the control region
    localparam logic [7:0] SLOT_INFO = 8'd0;
    localparam logic [7:0] SLOT_DFLT = 8'd1;

    typedef struct packed {
        logic [31:0] irq_stat;
        logic [31:0] fiq_stat;
        logic [31:0] irq_vec;
        logic [31:0] fiq_vec;
    } out_t;

    function automatic logic [31:0] pack_status(input logic vld,
                                                input logic [PRI_W-1:0] pri,
                                                input logic [NUM_W-1:0] num);
        return {vld, 11'b0, pri, 6'b0, num};
    endfunction
endpackage

// File: rtl/irqp_cfg.sv
module irqp_cfg
    import irqp_pkg::*;
#(
    parameter int N_INT = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADR_W-1:0]            addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic [N_INT-1:0][PRI_W-1:0] pri_o,
    output logic [N_INT-1:0][VEC_W-1:0] vec_o,
    output logic [VEC_W-1:0]            dflt_o
);
    localparam int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1;

    typedef struct packed {
        logic [N_INT-1:0][PRI_W-1:0] pri;
        logic [N_INT-1:0][VEC_W-1:0] vec;
        logic [VEC_W-1:0]            dflt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [1:0]       rgn;
    logic [7:0]       slot;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             unused_bits;

    assign rgn         = addr[11:10];
    assign slot        = addr[9:2];
    assign idx         = slot[IDX_W-1:0];
    assign in_range    = int'(slot) < N_INT;
    assign unused_bits = ^{wdata[1:0], addr[1:0]};

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (rgn)
                RGN_CTRL: if (slot == SLOT_DFLT) cfg_d.dflt = wdata[31:2];
                RGN_PRI:  if (in_range) cfg_d.pri[idx] = wdata[PRI_W-1:0];
                RGN_VEC:  if (in_range) cfg_d.vec[idx] = wdata[31:2];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.pri  <= '1;
            cfg_q.vec  <= '0;
            cfg_q.dflt <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rgn)
            RGN_CTRL: begin
                if (slot == SLOT_INFO) rdata = {21'b0, 11'(N_INT)};
                else if (slot == SLOT_DFLT) rdata = {cfg_q.dflt, 2'b00};
            end
            RGN_PRI:  if (in_range) rdata = {{(32-PRI_W){1'b0}}, cfg_q.pri[idx]};
            RGN_VEC:  if (in_range) rdata = {cfg_q.vec[idx], 2'b00};
            default:  ;
        endcase
    end

    assign pri_o  = cfg_q.pri;
    assign vec_o  = cfg_q.vec;
    assign dflt_o = cfg_q.dflt;

    // R8
    dflt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rgn == RGN_CTRL && slot == SLOT_DFLT) |=> (dflt_o == $past(wdata[31:2])));
endmodule

// File: rtl/irqp_arb.sv
module irqp_arb
    import irqp_pkg::*;
#(
    parameter int N_INT = 64,
    localparam int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_INT-1:0]            cand,
    input  logic [N_INT-1:0][PRI_W-1:0] pri,
    output logic                        win_vld,
    output logic [PRI_W-1:0]            win_pri,
    output logic [IDX_W-1:0]            win_idx
);
    // Ascending scan with a strict compare: an equal value never displaces
    // an earlier (lower-numbered) holder.
    always_comb begin
        win_vld = 1'b0;
        win_pri = '0;
        win_idx = '0;
        for (int i = 0; i < N_INT; i++) begin
            if (cand[i] && (!win_vld || pri[i] < win_pri)) begin
                win_vld = 1'b1;
                win_pri = pri[i];
                win_idx = IDX_W'(i);
            end
        end
    end

    // R5
    win_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> cand[win_idx]);
    // R10
    win_needs_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld == (|cand)));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irqp_pkg::*;
#(
    parameter int N_INT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INT-1:0] req_pend,
    input  logic [N_INT-1:0] req_fiq,
    input  logic [N_INT-1:0] vec_ded,
    input  logic             bus_we,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [31:0]      irq_stat,
    output logic [31:0]      fiq_stat,
    output logic [31:0]      irq_vec,
    output logic [31:0]      fiq_vec
);
    localparam int IDX_W   = (N_INT > 1) ? $clog2(N_INT) : 1;
    localparam int N_CLASS = 2;   // 0 = IRQ, 1 = FIQ

    logic [N_INT-1:0][PRI_W-1:0] pri;
    logic [N_INT-1:0][VEC_W-1:0] vec;
    logic [VEC_W-1:0]            dflt;

    logic [N_CLASS-1:0][N_INT-1:0] cand;
    logic [N_CLASS-1:0]            win_vld;
    logic [N_CLASS-1:0][PRI_W-1:0] win_pri;
    logic [N_CLASS-1:0][IDX_W-1:0] win_idx;
    logic [N_CLASS-1:0][31:0]      win_vec;

    out_t out_d, out_q;

    irqp_cfg #(.N_INT(N_INT)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .pri_o  (pri),
        .vec_o  (vec),
        .dflt_o (dflt)
    );

    for (genvar c = 0; c < N_CLASS; c++) begin : g_class
        assign cand[c] = req_pend & ((c == 1) ? req_fiq : ~req_fiq);

        irqp_arb #(.N_INT(N_INT)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .cand    (cand[c]),
            .pri     (pri),
            .win_vld (win_vld[c]),
            .win_pri (win_pri[c]),
            .win_idx (win_idx[c])
        );

        always_comb begin
            win_vec[c] = '0;
            if (win_vld[c])
                win_vec[c] = vec_ded[win_idx[c]] ? {dflt, 2'b00}
                                                 : {vec[win_idx[c]], 2'b00};
        end
    end

    always_comb begin
        out_d.irq_stat = pack_status(win_vld[0], win_pri[0], NUM_W'(win_idx[0]));
        out_d.fiq_stat = pack_status(win_vld[1], win_pri[1], NUM_W'(win_idx[1]));
        out_d.irq_vec  = win_vec[0];
        out_d.fiq_vec  = win_vec[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_stat = out_q.irq_stat;
    assign fiq_stat = out_q.fiq_stat;
    assign irq_vec  = out_q.irq_vec;
    assign fiq_vec  = out_q.fiq_vec;

    // R10
    irq_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|cand[0]) |=> (irq_stat == 32'h0 && irq_vec == 32'h0));
    // R11
    irq_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand[0]) |=> irq_stat[31]);
    // R11
    fiq_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand[1]) |=> fiq_stat[31]);
    // R8
    irq_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld[0] && vec_ded[win_idx[0]]) |=> (irq_vec == {$past(dflt), 2'b00}));
endmodule

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;
    localparam int  N       = 64;
    localparam time CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_pend = '0, req_fiq = '0, vec_ded = '0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata, irq_stat, fiq_stat, irq_vec, fiq_vec;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    irq_prio_resolver #(.N_INT(N)) uut (.*);

    always #(CLK_PER/2) clk = ~clk;

    typedef struct packed {
        logic [63:0] pend;
        logic [63:0] fiq;
        logic [63:0] ded;
        logic [31:0] irq_s;
        logic [31:0] fiq_s;
    } row_t;

    localparam int NROWS = 9;
    localparam row_t TBL [NROWS] = '{
        // R10: nothing pending
        '{64'h0, 64'h0, 64'h0, 32'h0, 32'h0},
        // R3: ints 0,1 at reset priority F
        '{64'h3, 64'h0, 64'h0, 32'h800F_0000, 32'h0},
        // R3: ints 3,5 tie at 2, int 7 at F
        '{64'hA8, 64'h0, 64'h0, 32'h8002_0003, 32'h0},
        // R2: 5(2), 10(1), 63(7)
        '{64'h8000_0000_0000_0420, 64'h0, 64'h0, 32'h8001_000A, 32'h0},
        // R5: 10 irq, 40 fiq
        '{64'h0000_0100_0000_0400, 64'h0000_0100_0000_0000, 64'h0, 32'h8001_000A, 32'h8000_0028},
        // R5: all fiq, 40 at 0 wins
        '{64'h8000_0100_0000_0008, 64'h8000_0100_0000_0008, 64'h0, 32'h0, 32'h8000_0028},
        // R4: top indices 63 irq, 62 fiq
        '{64'hC000_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h0, 32'h8007_003F, 32'h800F_003E},
        // R8: error on irq winner 10
        '{64'h408, 64'h8, 64'h400, 32'h8001_000A, 32'h8002_0003},
        // R8: error on a loser only
        '{64'h420, 64'h0, 64'h20, 32'h8001_000A, 32'h0}
    };

    localparam logic [31:0] DFLT_W = 32'hDEAD_BEEF;
    localparam logic [31:0] DFLT_R = 32'hDEAD_BEEC;

    function automatic logic [31:0] vec_of(input int n);
        return 32'h8000_0000 | (32'(n) << 4);
    endfunction

    function automatic logic [31:0] exp_vec(input logic [31:0] st, input logic [63:0] ded);
        if (!st[31]) return 32'h0;
        if (ded[st[5:0]]) return DFLT_R;
        return vec_of(int'(st[9:0]));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state of outputs
        chk("R10 reset irq_stat", irq_stat, 32'h0);
        chk("R10 reset fiq_stat", fiq_stat, 32'h0);
        chk("R10 reset irq_vec", irq_vec, 32'h0);
        chk("R10 reset fiq_vec", fiq_vec, 32'h0);
        rd(12'h400, r); chk("R1 priority reset", r, 32'hF);
        rd(12'h4FC, r); chk("R1 last priority reset", r, 32'hF);
        rd(12'h000, r); chk("R9 info word", r, 32'd64);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, r); chk("R9 info write ignored", r, 32'd64);

        // configuration
        wr(12'h400 + 12'd20 * 4, 32'hFFFF_FFF3);
        rd(12'h400 + 12'd20 * 4, r); chk("R1 upper priority bits", r, 32'h3);
        wr(12'h400 + 12'd3 * 4, 32'h2);
        wr(12'h400 + 12'd5 * 4, 32'h2);
        wr(12'h400 + 12'd10 * 4, 32'h1);
        wr(12'h400 + 12'd40 * 4, 32'h0);
        wr(12'h400 + 12'd63 * 4, 32'h7);
        for (int i = 0; i < N; i++) wr(12'h800 + 12'(i * 4), vec_of(i) | 32'h3);
        rd(12'h800 + 12'd7 * 4, r); chk("R6 vector low bits", r, vec_of(7));
        wr(12'h004, DFLT_W);
        rd(12'h004, r); chk("R8 fallback readback", r, DFLT_R);

        // table of request patterns
        for (int k = 0; k < NROWS; k++) begin
            req_pend = TBL[k].pend; req_fiq = TBL[k].fiq; vec_ded = TBL[k].ded;
            @(negedge clk);
            chk($sformatf("R4 irq status row %0d", k), irq_stat, TBL[k].irq_s);
            chk($sformatf("R5 fiq status row %0d", k), fiq_stat, TBL[k].fiq_s);
            chk($sformatf("R7 irq vector row %0d", k), irq_vec, exp_vec(TBL[k].irq_s, TBL[k].ded));
            chk($sformatf("R7 fiq vector row %0d", k), fiq_vec, exp_vec(TBL[k].fiq_s, TBL[k].ded));
        end

        // R11: one-cycle latency from request to status
        req_pend = '0; req_fiq = '0; vec_ded = '0;
        @(negedge clk);
        req_pend = 64'h400;
        #1 chk("R11 before edge", irq_stat, 32'h0);
        @(negedge clk);
        chk("R11 after one edge", irq_stat, 32'h8001_000A);

        // R11: priority write reaches status two edges after issue
        req_pend = 64'h420;
        @(negedge clk);
        wr(12'h400 + 12'd10 * 4, 32'h9);
        chk("R11 priority write latency", irq_stat, 32'h8001_000A);
        @(negedge clk);
        chk("R2 after reprioritise", irq_stat, 32'h8002_0005);
        chk("R7 after reprioritise", irq_vec, vec_of(5));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule